// File: doc/BRIEF.md
# Two-Way Set-Associative Load Cache

This block is a small data cache placed between a pipelined core's memory stage and a byte-addressed backing memory. It holds eight one-word lines organised as four sets of two ways. Loads that the core marks with a use-cache qualifier are looked up. A resident word is returned in the same cycle. A missing word is taken from backing memory in the same cycle, passed through to the core, and installed in the set so that the next load of that word hits.

Stores always go straight through to backing memory. A store to a word that is already cached also refreshes the cached copy. A store to a word that is not cached leaves the cache contents as they were. Each set keeps one least-recently-used bit that chooses which way a fill replaces. Because each set has two ways, two words that share a set index (for example 0x4 and 0x24) can be resident together. In a direct-mapped arrangement of the same size, those two words would keep evicting each other.

Top module: `dcache2w`

## Requirements
- R1: After reset every line is invalid: with idle inputs `hit` is 0, and the first qualified load of any word misses.
- R2: `hit` is 1 only for a qualified load (`use_cache`=1, `rd_en`=1, `wr_en`=0) of a resident word. A load with `use_cache`=0 reports no hit, is served from memory and installs nothing. A store never reports a hit.
- R3: Address bits [1:0] are a byte offset and play no part in the lookup. Bits [3:2] select the set and bits [31:4] form the tag, so 0x4 and 0x7 are the same word, while 0x4 and 0x14 are different words in the same set.
- R4: On a qualified load miss, `mem_rd_en` is 1 and `rdata` equals `mem_rdata` in the same cycle, and that word is installed at the clock edge, so that an immediately following load of the same word hits.
- R5: On a hit, `rdata` is the cached word and `mem_rd_en` is 0.
- R6: Two words with the same set index and different tags (0x4 and 0x24) are resident together: a loop alternating between them misses only on its first two loads.
- R7: A fill uses an invalid way of the set if there is one, checking way 0 first, and otherwise the least recently used way. Qualified load hits and fills both mark the way they used as most recent.
- R8: Every store drives `mem_wr_en`=1 with `mem_addr` and `mem_wdata` equal to the store's address and data.
- R9: A store to a resident word also updates the cached copy, and a later hit returns the stored value. A store to a non-resident word installs nothing, so the next qualified load of that word misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_cache | input | 1 | Qualifier marking a cacheable word load |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store data |
| hit | output | 1 | Qualified load found its word resident |
| rdata | output | 32 | Load data (cached word or memory word) |
| mem_rd_en | output | 1 | Read request to backing memory |
| mem_wr_en | output | 1 | Write request to backing memory |
| mem_addr | output | 32 | Backing memory byte address |
| mem_wdata | output | 32 | Backing memory write data |
| mem_rdata | input | 32 | Word returned by backing memory |

## Verification
The bench builds the cache with its default of four sets, which gives a two-bit index at bits [3:2] and a 28-bit tag. With that layout, 0x4, 0x24 and 0x44 all fall into set 1 with distinct tags. This lets the bench exercise the two-way conflict case, eviction of the least recently used way by a third word, and the refill of the evicted word. Four sets also make 0x8 a separate set, which keeps the store-miss and no-allocate checks apart from the set 1 traffic.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 2;
    localparam int NWAYS  = 2;

    typedef enum logic {
        WAY0 = 1'b0,
        WAY1 = 1'b1
    } way_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_BYPASS = 2'd2,
        OP_STORE  = 2'd3
    } op_e;

    // A store takes precedence; a read is cacheable only with the qualifier.
    function automatic op_e classify(input logic qual, input logic rd, input logic wr);
        if (wr)
            return OP_STORE;
        else if (rd && qual)
            return OP_LOAD;
        else if (rd)
            return OP_BYPASS;
        else
            return OP_IDLE;
    endfunction

    // Fill target: the first empty way, otherwise the least recently used one.
    function automatic way_e pick_victim(input logic [NWAYS-1:0] vld, input way_e lru);
        if (!vld[0])
            return WAY0;
        else if (!vld[1])
            return WAY1;
        else
            return lru;
    endfunction

    function automatic way_e other_way(input way_e w);
        return (w == WAY0) ? WAY1 : WAY0;
    endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store
    import dc_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int TAG_W = 28,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             wr_en,
    input  way_e             wr_way,
    output logic [NWAYS-1:0] match,
    output logic [NWAYS-1:0] vld
);

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;
        logic             sel;

        assign sel = wr_en && (wr_way == way_e'(w));

        always_ff @(posedge clk) begin
            if (rst)
                vld_q <= '0;
            else if (sel)
                vld_q[idx] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (sel)
                tag_q[idx] <= cmp_tag;
        end

        assign vld[w]   = vld_q[idx];
        assign match[w] = vld_q[idx] && (tag_q[idx] == cmp_tag);
    end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store
    import dc_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  way_e              wr_way,
    input  logic [DATA_W-1:0] wr_data,
    input  way_e              rd_way,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] way_word [NWAYS];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [DATA_W-1:0] word_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == way_e'(w)))
                word_q[idx] <= wr_data;
        end

        assign way_word[w] = word_q[idx];
    end

    assign rd_data = way_word[rd_way];

endmodule

// File: rtl/dc_lru_bits.sv
module dc_lru_bits
    import dc_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  way_e             used_way,
    output way_e             lru_way
);

    way_e lru_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                lru_q[s] <= WAY0;
        end else if (touch) begin
            lru_q[idx] <= other_way(used_way);
        end
    end

    assign lru_way = lru_q[idx];

endmodule

// File: rtl/dcache2w.sv
module dcache2w
    import dc_pkg::*;
#(
    parameter int SETS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              use_cache,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    op_e               op;
    logic [NWAYS-1:0]  match;
    logic [NWAYS-1:0]  vld;
    logic              resident;
    way_e              hit_way;
    way_e              lru_way;
    way_e              victim;
    logic              load_hit;
    logic              load_fill;
    logic              store_upd;
    logic [DATA_W-1:0] cached_word;

    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];
    assign op  = classify(use_cache, rd_en, wr_en);

    dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .cmp_tag (tag),
        .wr_en   (load_fill),
        .wr_way  (victim),
        .match   (match),
        .vld     (vld)
    );

    assign resident  = |match;
    assign hit_way   = match[1] ? WAY1 : WAY0;
    assign victim    = pick_victim(vld, lru_way);
    assign load_hit  = (op == OP_LOAD) && resident;
    assign load_fill = (op == OP_LOAD) && !resident;
    assign store_upd = (op == OP_STORE) && resident;

    dc_data_store #(.SETS(SETS)) u_data (
        .clk     (clk),
        .idx     (idx),
        .wr_en   (load_fill || store_upd),
        .wr_way  (load_fill ? victim : hit_way),
        .wr_data (load_fill ? mem_rdata : wdata),
        .rd_way  (hit_way),
        .rd_data (cached_word)
    );

    dc_lru_bits #(.SETS(SETS)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx),
        .touch    (load_hit || load_fill),
        .used_way (load_fill ? victim : hit_way),
        .lru_way  (lru_way)
    );

    assign hit       = load_hit;
    assign rdata     = load_hit ? cached_word : mem_rdata;
    assign mem_rd_en = ((op == OP_LOAD) || (op == OP_BYPASS)) && !load_hit;
    assign mem_wr_en = (op == OP_STORE);
    assign mem_addr  = addr;
    assign mem_wdata = wdata;

endmodule

// File: rtl/dc_checker.sv
module dc_checker (
    input logic        clk,
    input logic        rst,
    input logic        use_cache,
    input logic        rd_en,
    input logic        wr_en,
    input logic [29:0] waddr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        hit
);

    logic qload;
    assign qload = use_cache && rd_en && !wr_en;

    AST_RESET_COLD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit); // R1

    AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        hit |-> qload); // R2

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(qload) && !$past(hit) && qload && waddr == $past(waddr)) |-> hit); // R4

    AST_HIT_REPEAT_DATA: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit) && hit && waddr == $past(waddr)) |-> rdata == $past(rdata)); // R5

    AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && hit && waddr == $past(waddr)) |-> rdata == $past(wdata)); // R9

endmodule

bind dcache2w dc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .use_cache (use_cache),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .waddr     (addr[31:2]),
    .wdata     (wdata),
    .rdata     (rdata),
    .hit       (hit)
);

// File: tb/dcache2w_test.sv
module dcache2w_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        use_cache = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        hit;
    logic [31:0] rdata;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    logic        bd_we = 1'b0;
    logic [5:0]  bd_idx = '0;
    logic [31:0] bd_data = '0;
    logic [31:0] bmem [64];

    int n_chk  = 0;
    int n_fail = 0;

    logic        s_hit;
    logic [31:0] s_rdata;
    logic        s_mrd;
    logic        s_mwr;
    logic [31:0] s_maddr;
    logic [31:0] s_mwdata;

    always #5 clk = ~clk;

    dcache2w uut (
        .clk       (clk),
        .rst       (rst),
        .use_cache (use_cache),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .hit       (hit),
        .rdata     (rdata),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Backing memory: 64 words, asynchronous read, written at the clock edge.
    assign mem_rdata = bmem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++)
                bmem[i] <= 32'hA500_0000 | 32'(i);
        end else if (bd_we) begin
            bmem[bd_idx] <= bd_data;
        end else if (mem_wr_en) begin
            bmem[mem_addr[7:2]] <= mem_wdata;
        end
    end

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return 32'hA500_0000 | {26'd0, a[7:2]};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; use_cache = 1'b0; bd_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input logic uc, input logic rd, input logic wr,
                          input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        use_cache = uc; rd_en = rd; wr_en = wr; addr = a; wdata = d;
        #1;
        s_hit = hit; s_rdata = rdata; s_mrd = mem_rd_en;
        s_mwr = mem_wr_en; s_maddr = mem_addr; s_mwdata = mem_wdata;
    endtask

    task automatic qload(input logic [31:0] a);
        access(1'b1, 1'b1, 1'b0, a, 32'd0);
    endtask

    task automatic backdoor(input logic [5:0] i, input logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; use_cache = 1'b0;
        bd_we = 1'b1; bd_idx = i; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic t_reset_cold();
        do_reset();
        #1;
        chk("R1 idle hit after reset", 32'(hit), 32'd0);
        qload(32'h4);
        chk("R1 first load misses", 32'(s_hit), 32'd0);
        chk("R4 miss requests memory", 32'(s_mrd), 32'd1);
        chk("R4 miss data from memory", s_rdata, init_word(32'h4));
        qload(32'h24);
        chk("R1 second word misses", 32'(s_hit), 32'd0);
        qload(32'h24);
        chk("R4 refetched word hits", 32'(s_hit), 32'd1);
    endtask

    task automatic t_pingpong();
        do_reset();
        qload(32'h4);
        qload(32'h24);
        for (int k = 0; k < 3; k++) begin
            qload(32'h4);
            chk("R6 0x4 stays resident", 32'(s_hit), 32'd1);
            chk("R5 0x4 cached data", s_rdata, init_word(32'h4));
            chk("R5 hit makes no fetch", 32'(s_mrd), 32'd0);
            qload(32'h24);
            chk("R6 0x24 stays resident", 32'(s_hit), 32'd1);
            chk("R5 0x24 cached data", s_rdata, init_word(32'h24));
        end
    endtask

    task automatic t_offset();
        do_reset();
        qload(32'h4);
        qload(32'h7);
        chk("R3 byte offset ignored", 32'(s_hit), 32'd1);
        chk("R3 offset data", s_rdata, init_word(32'h4));
        qload(32'h14);
        chk("R3 other tag same set misses", 32'(s_hit), 32'd0);
        qload(32'h8);
        chk("R3 other set misses", 32'(s_hit), 32'd0);
        qload(32'h4);
        chk("R3 set1 word kept", 32'(s_hit), 32'd1);
        qload(32'h14);
        chk("R3 set1 second tag kept", 32'(s_hit), 32'd1);
    endtask

    task automatic t_qualifier();
        do_reset();
        qload(32'h4);
        access(1'b0, 1'b1, 1'b0, 32'h4, 32'd0);
        chk("R2 unqualified load no hit", 32'(s_hit), 32'd0);
        chk("R2 unqualified load fetches", 32'(s_mrd), 32'd1);
        chk("R2 unqualified load data", s_rdata, init_word(32'h4));
        access(1'b0, 1'b1, 1'b0, 32'h24, 32'd0);
        access(1'b0, 1'b1, 1'b0, 32'h44, 32'd0);
        access(1'b1, 1'b0, 1'b1, 32'h4, 32'h0BAD_F00D);
        chk("R2 store reports no hit", 32'(s_hit), 32'd0);
        qload(32'h4);
        chk("R2 resident word survives", 32'(s_hit), 32'd1);
        qload(32'h24);
        chk("R2 unqualified load did not allocate", 32'(s_hit), 32'd0);
    endtask

    task automatic t_lru();
        do_reset();
        qload(32'h4);
        qload(32'h24);
        qload(32'h4);
        qload(32'h44);
        chk("R7 third tag misses", 32'(s_hit), 32'd0);
        qload(32'h4);
        chk("R7 recently used 0x4 kept", 32'(s_hit), 32'd1);
        qload(32'h44);
        chk("R7 filled 0x44 hits", 32'(s_hit), 32'd1);
        chk("R7 0x44 data", s_rdata, init_word(32'h44));
        qload(32'h24);
        chk("R7 LRU 0x24 was evicted", 32'(s_hit), 32'd0);
        qload(32'h4);
        chk("R7 0x4 now least recent, evicted", 32'(s_hit), 32'd0);
        qload(32'h24);
        chk("R7 0x24 refilled", 32'(s_hit), 32'd1);
    endtask

    task automatic t_store();
        do_reset();
        qload(32'h4);
        access(1'b0, 1'b0, 1'b1, 32'h4, 32'hDEAD_BEEF);
        chk("R8 store write enable", 32'(s_mwr), 32'd1);
        chk("R8 store address", s_maddr, 32'h4);
        chk("R8 store data", s_mwdata, 32'hDEAD_BEEF);
        backdoor(6'd1, 32'h1111_1111);
        qload(32'h4);
        chk("R9 store hit refreshed copy", 32'(s_hit), 32'd1);
        chk("R9 cached store value", s_rdata, 32'hDEAD_BEEF);
        access(1'b0, 1'b0, 1'b1, 32'h8, 32'hCAFE_F00D);
        chk("R8 store miss write enable", 32'(s_mwr), 32'd1);
        qload(32'h8);
        chk("R9 store miss no allocate", 32'(s_hit), 32'd0);
        chk("R8 memory got store", s_rdata, 32'hCAFE_F00D);
        qload(32'h8);
        chk("R4 load after store miss fills", 32'(s_hit), 32'd1);
        chk("R4 filled data", s_rdata, 32'hCAFE_F00D);
    endtask

    initial begin
        t_reset_cold();
        t_pingpong();
        t_offset();
        t_qualifier();
        t_lru();
        t_store();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule